// File: doc/BRIEF.md
# Thread Run Control Registers

This block is the register front end that a service processor uses to steer the hardware threads of one processor core. It sits on a 64-bit register access bus. Every access carries a byte address and a size code, and the register offset is the byte address shifted right by three. A single command register takes stop, start, soft-reset and clear-maintenance requests for each thread. Two status registers report which threads are halted and which threads have been quiesced by a stop.

Commands turn into single-cycle pulses on per-thread pause, resume and soft-reset outputs, and they update a per-thread quiesced flag inside the block. Every field is numbered MSB-0, so field bit n is word bit 63−n, and each thread owns an 8-bit lane. The core may carry fewer threads than the four lane slots. Lanes for threads that are not present do nothing on write and read as zero.

Top module: `thread_run_ctl`

## Requirements
- R1: The register offset is `acc_addr >> 3`, and the low three address bits are ignored. Only size code 3 (8 bytes) is accepted. A write with any other size has no effect, and a read with any other size returns zero data.
- R2: A command write is an accepted write to offset 0x449. In a command write, MSB-0 bit 7+8i (word bit 56−8i) is stop for thread i. Stop gives a one-cycle `thr_pause[i]` pulse in the cycle after the write and sets the quiesced flag of thread i.
- R3: In a command write, MSB-0 bit 6+8i (start, word bit 57−8i) or MSB-0 bit 3+8i (clear-maintenance, word bit 60−8i) clears the quiesced flag of thread i. Either bit gives a one-cycle `thr_resume[i]` pulse in the cycle after the write. The two bits have the same effect.
- R4: In a command write, MSB-0 bit 4+8i (soft reset, word bit 59−8i) clears the quiesced flag of thread i and gives a one-cycle `thr_sreset[i]` pulse in the cycle after the write.
- R5: The commands for one thread in one write take effect in this order: stop, start, soft reset, clear-maintenance. If stop is combined with any clearing command, all the requested pulses fire together and the thread ends up not quiesced.
- R6: A read of offset 0x412 returns MSB-0 bit 56+i (word bit 7−i) equal to `thr_halted[i]` as sampled at the read, and MSB-0 bit 62 (word bit 1) equal to `cfg_single_partition`. All other bits are zero.
- R7: A read of offset 0x454 returns MSB-0 bits 8i and 8i+1 (word bits 63−8i and 62−8i) both set when thread i is quiesced. All other bits are zero.
- R8: Reads of offset 0x413, of the command register and of any other offset return zero. Writes to other offsets, and unrecognised bits in a command write, cause no pulse and no change of state.
- R9: `NUM_THREADS` is 1 to 4. Command bits in lanes at or above `NUM_THREADS` are ignored, and status bits for those lanes read as zero.
- R10: A synchronous active-high reset clears every quiesced flag, every pulse output, `rd_valid` and `rd_data`.
- R11: Every read request, accepted or not, is answered by `rd_valid` high for exactly one cycle on the cycle after the request, with `rd_data` in the same cycle. `rd_valid` is never high at any other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Access request this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | ADDR_W | Byte address of the access |
| acc_size | input | 2 | log2 of the access size in bytes; only 3 is valid |
| acc_wdata | input | 64 | Write data, MSB-0 numbering |
| rd_valid | output | 1 | Read response strobe |
| rd_data | output | 64 | Read response data |
| thr_halted | input | NUM_THREADS | Halted state reported by each thread |
| cfg_single_partition | input | 1 | Core runs one logical partition per core |
| thr_pause | output | NUM_THREADS | Pause pulse per thread |
| thr_resume | output | NUM_THREADS | Resume pulse per thread |
| thr_sreset | output | NUM_THREADS | Soft-reset-resume pulse per thread |

## Verification
A quiesced flag that is wrong shows nothing at the pulse outputs. It becomes visible only through the health register: a read issued one cycle later returns a wrong lane in the next cycle. The bench therefore follows every command write with health reads, and also keeps a behavioural model that compares every cycle. A wrong command decode or lane mapping shows one cycle after the write, as a pulse on the wrong thread or a missing pulse. Decode faults on the read side, such as swapped halted lanes, a misplaced partition bit or a wrong offset match, show in the `rd_data` of the very next cycle.

// File: rtl/thread_run_ctl_pkg.sv
package thread_run_ctl_pkg;

  localparam int unsigned WORD_W      = 64;
  localparam int unsigned LANE_W      = 8;
  localparam int unsigned MAX_THREADS = 4;

  // register offsets (byte address >> 3)
  localparam int unsigned OFS_RUNCMD   = 'h449;
  localparam int unsigned OFS_RUNSTATE = 'h412;
  localparam int unsigned OFS_RUNINFO  = 'h413;
  localparam int unsigned OFS_HEALTH   = 'h454;

  // size code for an 8-byte access
  localparam logic [1:0] SIZE_8B = 2'd3;

  // MSB-0 positions inside a thread lane
  localparam int unsigned POS_STOP     = 7;
  localparam int unsigned POS_START    = 6;
  localparam int unsigned POS_SRESET   = 4;
  localparam int unsigned POS_CLRMAINT = 3;
  localparam int unsigned POS_HALT0    = 56;
  localparam int unsigned POS_ONEPART  = 62;

  typedef struct packed {
    logic stop;
    logic start;
    logic sreset;
    logic clrmaint;
  } lane_cmd_t;

  typedef enum logic [1:0] {
    SEL_ZERO   = 2'd0,
    SEL_STATE  = 2'd1,
    SEL_HEALTH = 2'd2
  } rd_sel_t;

  // word bit index of MSB-0 bit n
  function automatic int unsigned msb0(input int unsigned n);
    return WORD_W - 1 - n;
  endfunction

endpackage

// File: rtl/trc_decode.sv
module trc_decode
  import thread_run_ctl_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [1:0]        acc_size,
  output logic              cmd_wr,
  output logic              rd_req,
  output rd_sel_t           rd_sel
);
  localparam int unsigned OFF_W = ADDR_W - 3;

  logic [OFF_W-1:0] offset;
  logic             acc_ok;
  logic             unused_low;

  // R1: offset is the byte address shifted by three
  assign offset     = acc_addr[ADDR_W-1:3];
  assign unused_low = ^acc_addr[2:0];
  assign acc_ok     = acc_valid && (acc_size == SIZE_8B);

  assign cmd_wr = acc_ok && acc_write && (offset == OFF_W'(OFS_RUNCMD));
  assign rd_req = acc_valid && !acc_write;

  always_comb begin
    rd_sel = SEL_ZERO;
    if (acc_ok && !acc_write) begin
      if (offset == OFF_W'(OFS_RUNSTATE))
        rd_sel = SEL_STATE;
      else if (offset == OFF_W'(OFS_HEALTH))
        rd_sel = SEL_HEALTH;
      // R8: thread-info, command register and unknown offsets read zero
    end
  end
endmodule

// File: rtl/trc_lane.sv
module trc_lane
  import thread_run_ctl_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      cmd_wr,
  input  lane_cmd_t cmd,
  output logic      quiesced,
  output logic      pause_p,
  output logic      resume_p,
  output logic      sreset_p
);
  logic q_r;
  logic q_nxt;

  // R5: effects applied in the order stop, start, soft reset, clear-maintenance
  always_comb begin
    q_nxt = q_r;
    if (cmd_wr) begin
      if (cmd.stop)     q_nxt = 1'b1;
      if (cmd.start)    q_nxt = 1'b0;
      if (cmd.sreset)   q_nxt = 1'b0;
      if (cmd.clrmaint) q_nxt = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q_r      <= 1'b0;
      pause_p  <= 1'b0;
      resume_p <= 1'b0;
      sreset_p <= 1'b0;
    end else begin
      q_r      <= q_nxt;
      pause_p  <= cmd_wr && cmd.stop;                     // R2
      resume_p <= cmd_wr && (cmd.start || cmd.clrmaint);  // R3
      sreset_p <= cmd_wr && cmd.sreset;                   // R4
    end
  end

  assign quiesced = q_r;
endmodule

// File: rtl/trc_readback.sv
module trc_readback
  import thread_run_ctl_pkg::*;
#(
  parameter int unsigned NUM_THREADS = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   rd_req,
  input  rd_sel_t                rd_sel,
  input  logic [NUM_THREADS-1:0] halted,
  input  logic [NUM_THREADS-1:0] quiesced,
  input  logic                   one_part,
  output logic                   rd_valid,
  output logic [WORD_W-1:0]      rd_data
);
  logic [WORD_W-1:0] state_word;
  logic [WORD_W-1:0] health_word;
  logic [WORD_W-1:0] sel_word;

  // R6 / R9: only present threads contribute
  always_comb begin
    state_word = '0;
    for (int i = 0; i < int'(NUM_THREADS); i++)
      state_word[msb0(POS_HALT0 + i)] = halted[i];
    state_word[msb0(POS_ONEPART)] = one_part;
  end

  // R7 / R9
  always_comb begin
    health_word = '0;
    for (int i = 0; i < int'(NUM_THREADS); i++) begin
      health_word[msb0(LANE_W * i)]     = quiesced[i];
      health_word[msb0(LANE_W * i + 1)] = quiesced[i];
    end
  end

  always_comb begin
    unique case (rd_sel)
      SEL_STATE:  sel_word = state_word;
      SEL_HEALTH: sel_word = health_word;
      default:    sel_word = '0;
    endcase
  end

  // R11: one registered response per read request
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_req;
      rd_data  <= rd_req ? sel_word : '0;
    end
  end
endmodule

// File: rtl/thread_run_ctl.sv
module thread_run_ctl
  import thread_run_ctl_pkg::*;
#(
  parameter int unsigned NUM_THREADS = 4,
  parameter int unsigned ADDR_W      = 32
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   acc_valid,
  input  logic                   acc_write,
  input  logic [ADDR_W-1:0]      acc_addr,
  input  logic [1:0]             acc_size,
  input  logic [63:0]            acc_wdata,
  output logic                   rd_valid,
  output logic [63:0]            rd_data,
  input  logic [NUM_THREADS-1:0] thr_halted,
  input  logic                   cfg_single_partition,
  output logic [NUM_THREADS-1:0] thr_pause,
  output logic [NUM_THREADS-1:0] thr_resume,
  output logic [NUM_THREADS-1:0] thr_sreset
);
  logic                   cmd_wr;
  logic                   rd_req;
  rd_sel_t                rd_sel;
  logic [NUM_THREADS-1:0] quiesced;
  logic                   unused_wdata;

  // R8: bits outside the recognised command fields are dropped
  assign unused_wdata = ^acc_wdata;

  trc_decode #(.ADDR_W(ADDR_W)) u_decode (
    .acc_valid (acc_valid),
    .acc_write (acc_write),
    .acc_addr  (acc_addr),
    .acc_size  (acc_size),
    .cmd_wr    (cmd_wr),
    .rd_req    (rd_req),
    .rd_sel    (rd_sel)
  );

  // R9: lanes are only built for threads that exist
  for (genvar g = 0; g < int'(NUM_THREADS); g++) begin : g_lane
    localparam int unsigned BASE = LANE_W * g;
    lane_cmd_t cmd;

    assign cmd.stop     = acc_wdata[msb0(BASE + POS_STOP)];
    assign cmd.start    = acc_wdata[msb0(BASE + POS_START)];
    assign cmd.sreset   = acc_wdata[msb0(BASE + POS_SRESET)];
    assign cmd.clrmaint = acc_wdata[msb0(BASE + POS_CLRMAINT)];

    trc_lane u_lane (
      .clk      (clk),
      .rst      (rst),
      .cmd_wr   (cmd_wr),
      .cmd      (cmd),
      .quiesced (quiesced[g]),
      .pause_p  (thr_pause[g]),
      .resume_p (thr_resume[g]),
      .sreset_p (thr_sreset[g])
    );
  end

  trc_readback #(.NUM_THREADS(NUM_THREADS)) u_readback (
    .clk      (clk),
    .rst      (rst),
    .rd_req   (rd_req),
    .rd_sel   (rd_sel),
    .halted   (thr_halted),
    .quiesced (quiesced),
    .one_part (cfg_single_partition),
    .rd_valid (rd_valid),
    .rd_data  (rd_data)
  );
endmodule

// File: rtl/thread_run_ctl_chk.sv
module thread_run_ctl_chk #(
  parameter int unsigned NUM_THREADS = 4,
  parameter int unsigned ADDR_W      = 32
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   acc_valid,
  input logic                   acc_write,
  input logic [ADDR_W-1:0]      acc_addr,
  input logic [1:0]             acc_size,
  input logic [63:0]            acc_wdata,
  input logic                   rd_valid,
  input logic [NUM_THREADS-1:0] thr_pause,
  input logic [NUM_THREADS-1:0] thr_resume,
  input logic [NUM_THREADS-1:0] thr_sreset,
  input logic [NUM_THREADS-1:0] q_state
);
  logic                   is_cmd;
  logic                   is_rd;
  logic [NUM_THREADS-1:0] want_stop;
  logic [NUM_THREADS-1:0] want_run;
  logic [NUM_THREADS-1:0] want_sr;
  logic                   unused_chk;

  assign unused_chk = ^acc_wdata;
  assign is_cmd = acc_valid && acc_write && (acc_size == 2'd3) &&
                  ((acc_addr >> 3) == ADDR_W'('h449));
  assign is_rd  = acc_valid && !acc_write;

  always_comb begin
    for (int i = 0; i < int'(NUM_THREADS); i++) begin
      want_stop[i] = acc_wdata[56 - 8 * i];
      want_run[i]  = acc_wdata[57 - 8 * i] | acc_wdata[60 - 8 * i];
      want_sr[i]   = acc_wdata[59 - 8 * i];
    end
  end

  // R2
  pause_match_chk: assert property (@(posedge clk) disable iff (rst)
    is_cmd |=> thr_pause == $past(want_stop));

  // R3
  resume_match_chk: assert property (@(posedge clk) disable iff (rst)
    is_cmd |=> thr_resume == $past(want_run));

  // R4
  sreset_match_chk: assert property (@(posedge clk) disable iff (rst)
    is_cmd |=> thr_sreset == $past(want_sr));

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !is_cmd |=> (thr_pause | thr_resume | thr_sreset) == '0);

  // R5
  clear_wins_chk: assert property (@(posedge clk) disable iff (rst)
    ((thr_resume | thr_sreset) & q_state) == '0);

  // R2
  stop_holds_chk: assert property (@(posedge clk) disable iff (rst)
    ((thr_pause & ~thr_resume & ~thr_sreset) & ~q_state) == '0);

  // R11
  rd_answered_chk: assert property (@(posedge clk) disable iff (rst)
    is_rd |=> rd_valid);

  // R11
  rd_only_on_req_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(is_rd));
endmodule

bind thread_run_ctl thread_run_ctl_chk #(
  .NUM_THREADS (NUM_THREADS),
  .ADDR_W      (ADDR_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .acc_valid  (acc_valid),
  .acc_write  (acc_write),
  .acc_addr   (acc_addr),
  .acc_size   (acc_size),
  .acc_wdata  (acc_wdata),
  .rd_valid   (rd_valid),
  .thr_pause  (thr_pause),
  .thr_resume (thr_resume),
  .thr_sreset (thr_sreset),
  .q_state    (quiesced)
);

// File: tb/thread_run_ctl_bench.sv
`timescale 1ns/1ps
module thread_run_ctl_bench;
  localparam int NT = 3;
  localparam int AW = 32;
  localparam logic [31:0] A_CMD    = 32'h0000_2248;
  localparam logic [31:0] A_STATE  = 32'h0000_2090;
  localparam logic [31:0] A_INFO   = 32'h0000_2098;
  localparam logic [31:0] A_HEALTH = 32'h0000_22A0;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          acc_valid = 1'b0;
  logic          acc_write = 1'b0;
  logic [AW-1:0] acc_addr  = '0;
  logic [1:0]    acc_size  = 2'd3;
  logic [63:0]   acc_wdata = '0;
  logic          rd_valid;
  logic [63:0]   rd_data;
  logic [NT-1:0] thr_halted = '0;
  logic          cfg_single_partition = 1'b0;
  logic [NT-1:0] thr_pause, thr_resume, thr_sreset;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  logic [NT-1:0] cap_pause, cap_resume, cap_sreset;
  logic          cap_rv;
  logic [63:0]   cap_rd;

  // behavioural model state
  logic [NT-1:0] m_q, m_p, m_r, m_s;
  logic          m_rv;
  logic [63:0]   m_rd;

  always #2 clk = ~clk;

  thread_run_ctl #(.NUM_THREADS(NT), .ADDR_W(AW)) u_thread_run_ctl (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_addr(acc_addr), .acc_size(acc_size), .acc_wdata(acc_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .thr_halted(thr_halted),
    .cfg_single_partition(cfg_single_partition), .thr_pause(thr_pause),
    .thr_resume(thr_resume), .thr_sreset(thr_sreset)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // model, advanced on every rising edge from the requirement text
  always @(posedge clk) begin
    int off;
    m_p = '0; m_r = '0; m_s = '0; m_rv = 1'b0; m_rd = '0;
    if (rst) begin
      m_q = '0;
    end else if (acc_valid) begin
      off = int'(acc_addr >> 3);
      if (!acc_write) m_rv = 1'b1;
      if (acc_size == 2'd3) begin
        if (acc_write && off == 'h449) begin
          for (int i = 0; i < NT; i++) begin
            if (acc_wdata[63 - (7 + 8*i)]) begin m_p[i] = 1; m_q[i] = 1; end
            if (acc_wdata[63 - (6 + 8*i)]) begin m_r[i] = 1; m_q[i] = 0; end
            if (acc_wdata[63 - (4 + 8*i)]) begin m_s[i] = 1; m_q[i] = 0; end
            if (acc_wdata[63 - (3 + 8*i)]) begin m_r[i] = 1; m_q[i] = 0; end
          end
        end else if (!acc_write && off == 'h412) begin
          for (int i = 0; i < NT; i++) m_rd[63 - (56 + i)] = thr_halted[i];
          m_rd[63 - 62] = cfg_single_partition;
        end else if (!acc_write && off == 'h454) begin
          for (int i = 0; i < NT; i++) begin
            m_rd[63 - 8*i]       = m_q[i];
            m_rd[63 - (8*i + 1)] = m_q[i];
          end
        end
      end
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      chk("R2 model pause",   64'(thr_pause),  64'(m_p));
      chk("R3 model resume",  64'(thr_resume), 64'(m_r));
      chk("R4 model sreset",  64'(thr_sreset), 64'(m_s));
      chk("R11 model rd_valid", 64'(rd_valid), 64'(m_rv));
      chk("R6 model rd_data", rd_data, m_rd);
    end
  end

  task automatic access(input logic wr, input logic [31:0] addr,
                        input logic [1:0] sz, input logic [63:0] d);
    @(negedge clk); #1;
    acc_valid = 1'b1; acc_write = wr; acc_addr = addr; acc_size = sz; acc_wdata = d;
    @(negedge clk);
    cap_pause = thr_pause; cap_resume = thr_resume; cap_sreset = thr_sreset;
    cap_rv = rd_valid; cap_rd = rd_data;
    #1;
    acc_valid = 1'b0; acc_write = 1'b0; acc_wdata = '0; acc_size = 2'd3;
  endtask

  task automatic read_health(input string tag, input logic [63:0] exp);
    access(1'b0, A_HEALTH, 2'd3, 64'd0);
    chk(tag, cap_rd, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10 reset state
    chk("R10 pause after reset", 64'(thr_pause), 0);
    chk("R10 rd_valid after reset", 64'(rd_valid), 0);
    #1 rst = 1'b0;
    read_health("R10 health after reset", 64'd0);

    // R2 stop thread 0 then thread 2
    access(1'b1, A_CMD, 2'd3, 64'h0100_0000_0000_0000);
    chk("R2 pause t0", 64'(cap_pause), 64'b001);
    chk("R11 no rd_valid on write", 64'(cap_rv), 0);
    read_health("R7 health t0", 64'hC000_0000_0000_0000);
    access(1'b1, A_CMD, 2'd3, 64'h0000_0100_0000_0000);
    chk("R2 pause t2", 64'(cap_pause), 64'b100);
    read_health("R7 health t0 t2", 64'hC000_C000_0000_0000);

    // R3 start t0, clear-maintenance t2
    access(1'b1, A_CMD, 2'd3, 64'h0200_0000_0000_0000);
    chk("R3 resume t0", 64'(cap_resume), 64'b001);
    read_health("R3 health t2 only", 64'h0000_C000_0000_0000);
    access(1'b1, A_CMD, 2'd3, 64'h0000_1000_0000_0000);
    chk("R3 clrmaint resume t2", 64'(cap_resume), 64'b100);
    read_health("R3 health clear", 64'd0);

    // R4 stop t1 then soft reset t1
    access(1'b1, A_CMD, 2'd3, 64'h0001_0000_0000_0000);
    access(1'b1, A_CMD, 2'd3, 64'h0008_0000_0000_0000);
    chk("R4 sreset t1", 64'(cap_sreset), 64'b010);
    read_health("R4 health after sreset", 64'd0);

    // R5 stop with sreset, and stop with start and clrmaint
    access(1'b1, A_CMD, 2'd3, 64'h0009_0000_0000_0000);
    chk("R5 pause t1", 64'(cap_pause), 64'b010);
    chk("R5 sreset t1", 64'(cap_sreset), 64'b010);
    read_health("R5 health stop+sreset", 64'd0);
    access(1'b1, A_CMD, 2'd3, 64'h1300_0000_0000_0000);
    chk("R5 pause t0", 64'(cap_pause), 64'b001);
    chk("R5 resume t0", 64'(cap_resume), 64'b001);
    read_health("R5 health stop+start", 64'd0);

    // R1 wrong size write and read, low address bits ignored
    access(1'b1, A_CMD, 2'd2, 64'h0001_0000_0000_0000);
    chk("R1 size2 write no pause", 64'(cap_pause), 0);
    read_health("R1 size2 write no state", 64'd0);
    thr_halted = 3'b111; cfg_single_partition = 1'b1;
    access(1'b0, A_STATE, 2'd1, 64'd0);
    chk("R1 size1 read valid", 64'(cap_rv), 1);
    chk("R1 size1 read zero", cap_rd, 64'd0);
    access(1'b1, A_CMD | 32'h5, 2'd3, 64'h0100_0000_0000_0000);
    chk("R1 unaligned low bits pause", 64'(cap_pause), 64'b001);
    access(1'b0, A_HEALTH | 32'h7, 2'd3, 64'd0);
    chk("R1 unaligned health", cap_rd, 64'hC000_0000_0000_0000);
    access(1'b1, A_CMD, 2'd3, 64'h0800_0000_0000_0000);

    // R8 other offsets, stray bits; R9 absent lane
    access(1'b1, A_CMD - 32'h8, 2'd3, 64'h0100_0100_0000_0000);
    chk("R8 other offset no pause", 64'(cap_pause), 0);
    access(1'b1, A_CMD, 2'd3, 64'hE400_0001_0000_0000);
    chk("R9 absent lane no pause", 64'(cap_pause), 0);
    chk("R8 stray bits no resume", 64'(cap_resume | cap_sreset), 0);
    read_health("R8 health untouched", 64'd0);
    access(1'b0, A_INFO, 2'd3, 64'd0);
    chk("R8 info reads zero", cap_rd, 64'd0);
    access(1'b0, A_CMD, 2'd3, 64'd0);
    chk("R8 command reads zero", cap_rd, 64'd0);

    // R6 thread state
    thr_halted = 3'b101; cfg_single_partition = 1'b1;
    access(1'b0, A_STATE, 2'd3, 64'd0);
    chk("R6 state 101 part", cap_rd, 64'h0000_0000_0000_00A2);
    thr_halted = 3'b010; cfg_single_partition = 1'b0;
    access(1'b0, A_STATE, 2'd3, 64'd0);
    chk("R6 state 010", cap_rd, 64'h0000_0000_0000_0040);
    thr_halted = 3'b111;
    access(1'b0, A_STATE, 2'd3, 64'd0);
    chk("R9 absent halted lane zero", cap_rd, 64'h0000_0000_0000_00E0);

    // mixed traffic checked against the model every cycle
    for (int k = 0; k < 400; k++) begin
      logic [31:0] a;
      logic [1:0]  sz;
      int          sel;
      sel = int'($urandom % 6);
      case (sel)
        0, 1: a = A_CMD;
        2:    a = A_STATE;
        3:    a = A_HEALTH;
        4:    a = A_INFO;
        default: a = $urandom % 32'h4000;
      endcase
      a  = a | ($urandom % 8);
      sz = (($urandom % 5) == 0) ? 2'($urandom % 3) : 2'd3;
      thr_halted = NT'($urandom);
      cfg_single_partition = 1'($urandom);
      access(sel < 2 ? 1'b1 : 1'($urandom), a, sz, {$urandom, $urandom});
    end

    repeat (2) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule